// File: doc/BRIEF.md
# Incrementing Qword Pattern Generator and Checker

This block is a traffic source and sink for a 64-bit streaming loopback test. A command write arms the transmit side, which pushes a counting pattern into a FIFO-style write port until a programmed number of 64-bit words has been accepted. The receive side drains a FIFO-style read port whenever it is not empty and can check every returned word against the same counting pattern.

Alongside the two live word counters, a 48-bit timer measures the whole transfer. It starts at the first accepted write and stops once the receive count reaches the programmed total, so software can read the elapsed cycles as a low and a high word after the run. Each run is started by a fresh command write, which clears the counters, the timer and the error flag.

Top module: `incr_pattern_tester`

## Requirements
- R1: A command write with `cmd_stop` = 0 makes `busy` high from the next cycle. A command write with `cmd_stop` = 1 leaves `busy` low, and no write is issued.
- R2: `tx_wr_en` is never high while `tx_full` is high. While `busy` is high and `tx_full` is low, `tx_wr_en` is high.
- R3: The n-th word written after a command (n from 0) carries 2n in bits [31:0] and 2n+1 in bits [63:32], both modulo 2^32.
- R4: Exactly `total_qw` words are written per run. `tx_count` then equals `total_qw`, and `busy` is low in the cycle after the last accepted write.
- R5: `rx_rd_en` is the inverse of `rx_empty`. Read data is taken one cycle after an enabled read, and `rx_count` rises by one for each such word. While the receive FIFO stays empty, `rx_count` does not move.
- R6: When `cmd_verify` was 1 at the command, a received word that differs from the R3 pattern for its receive index sets `fail` high.
- R7: When `cmd_verify` was 0 at the command, mismatching received data leaves `fail` low.
- R8: Once set, `fail` stays high until the next command write or a reset.
- R9: A command write clears `tx_count`, `rx_count`, `fail` and the timer to 0 in the next cycle. Reset gives the same values, with `busy` low.
- R10: The timer counts clock cycles from the edge after the first accepted write up to and including the edge after `rx_count` first equals `total_qw`, and then holds. Bits [31:0] appear on `timer_lo` and bits [47:32] on `timer_hi`.
- R11: A total of one word is a valid run: one write, one read, and the timer stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_stop | input | 1 | Command bit: 0 starts transmission, 1 leaves it idle |
| cmd_verify | input | 1 | Command bit: enables the receive data comparison |
| total_qw | input | 32 | Number of 64-bit words per run (1 to 2^32-1) |
| tx_full | input | 1 | Transmit FIFO full |
| tx_wr_en | output | 1 | Transmit FIFO write enable |
| tx_wr_data | output | 64 | Transmit FIFO write data |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_rd_en | output | 1 | Receive FIFO read enable |
| rx_rd_data | input | 64 | Receive FIFO read data, valid one cycle after the enable |
| busy | output | 1 | Transmission in progress |
| fail | output | 1 | Sticky data mismatch flag |
| tx_count | output | 32 | Words written in this run |
| rx_count | output | 32 | Words received in this run |
| timer_lo | output | 32 | Transfer timer bits [31:0] |
| timer_hi | output | 16 | Transfer timer bits [47:32] |

## Verification
Suppose the transmit counter drifts. The next write then shows a wrong pattern word, or the count at which `busy` drops is wrong. Both are visible within one cycle of the write in question. If the delayed read flag is misaligned, the checker compares the wrong word against the expected pattern, so a correct loopback raises `fail` within one cycle of the first received word. The receive count also goes wrong at the same point. If a timer start or stop flag is wrong, the final timer differs from the cycle distance that the bench measures between the first write and the receive count reaching the total, and the value keeps moving after the stop.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    localparam int QWORD_W = 64;
    localparam int LANE_W  = 32;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_RUN  = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic hold;
        logic verify;
    } cmd_t;

    typedef struct packed {
        logic started;
        logic stopped;
    } tmr_flags_t;

    // Two consecutive lane values per qword; the even value sits in the low lane.
    function automatic logic [QWORD_W-1:0] pattern_qword(input logic [LANE_W-1:0] idx);
        logic [LANE_W-1:0] even_v;
        even_v = {idx[LANE_W-2:0], 1'b0};
        return {even_v + LANE_W'(1), even_v};
    endfunction

endpackage

// File: rtl/ipg_tx_gen.sv
module ipg_tx_gen
    import ipg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_go,
    input  cmd_t                cmd,
    input  logic [CNT_W-1:0]    total,
    input  logic                fifo_full,
    output logic                wr_en,
    output logic [QWORD_W-1:0]  wr_data,
    output logic [CNT_W-1:0]    count,
    output logic                running
);

    tx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    assign running  = (state_q == TX_RUN);
    assign wr_en    = running && !fifo_full;
    assign cnt_next = cnt_q + CNT_W'(1);
    assign wr_data  = pattern_qword(LANE_W'(cnt_q));
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
        end else if (cmd_go) begin
            cnt_q   <= '0;
            state_q <= cmd.hold ? TX_IDLE : TX_RUN;
        end else if (wr_en) begin
            cnt_q <= cnt_next;
            if (cnt_next == total) begin
                state_q <= TX_IDLE;
            end
        end
    end

endmodule

// File: rtl/ipg_rx_check.sv
module ipg_rx_check
    import ipg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_go,
    input  cmd_t                cmd,
    input  logic                fifo_empty,
    input  logic [QWORD_W-1:0]  rd_data,
    output logic                rd_en,
    output logic [CNT_W-1:0]    count,
    output logic                fail
);

    logic                rd_vld_q;
    logic                verify_q;
    logic                fail_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [QWORD_W-1:0]  expect_w;
    logic                mismatch;

    assign rd_en    = !fifo_empty;
    assign expect_w = pattern_qword(LANE_W'(cnt_q));
    assign mismatch = rd_vld_q && verify_q && (rd_data != expect_w);
    assign count    = cnt_q;
    assign fail     = fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q <= 1'b0;
        end else begin
            rd_vld_q <= rd_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            verify_q <= 1'b0;
            fail_q   <= 1'b0;
        end else if (cmd_go) begin
            cnt_q    <= '0;
            verify_q <= cmd.verify;
            fail_q   <= 1'b0;
        end else begin
            if (rd_vld_q) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (mismatch) begin
                fail_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipg_xfer_timer.sv
module ipg_xfer_timer
    import ipg_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int TIMER_W = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               first_wr,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   total,
    output logic [TIMER_W-1:0] value
);

    tmr_flags_t         flags_q;
    logic [TIMER_W-1:0] tick_q;
    logic               reached;

    assign reached = flags_q.started && (rx_count == total);
    assign value   = tick_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flags_q <= '0;
            tick_q  <= '0;
        end else begin
            if (first_wr) begin
                flags_q.started <= 1'b1;
            end
            if (reached) begin
                flags_q.stopped <= 1'b1;
            end
            if (flags_q.started && !flags_q.stopped) begin
                tick_q <= tick_q + TIMER_W'(1);
            end
        end
    end

endmodule

// File: rtl/incr_pattern_tester.sv
module incr_pattern_tester
    import ipg_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int TIMER_W = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic                 cmd_stop,
    input  logic                 cmd_verify,
    input  logic [CNT_W-1:0]     total_qw,
    input  logic                 tx_full,
    output logic                 tx_wr_en,
    output logic [63:0]          tx_wr_data,
    input  logic                 rx_empty,
    output logic                 rx_rd_en,
    input  logic [63:0]          rx_rd_data,
    output logic                 busy,
    output logic                 fail,
    output logic [CNT_W-1:0]     tx_count,
    output logic [CNT_W-1:0]     rx_count,
    output logic [31:0]          timer_lo,
    output logic [TIMER_W-33:0]  timer_hi
);

    cmd_t               cmd_fields;
    logic [TIMER_W-1:0] timer_val;

    assign cmd_fields = '{hold: cmd_stop, verify: cmd_verify};

    ipg_tx_gen #(.CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .cmd_go    (cmd_wr),
        .cmd       (cmd_fields),
        .total     (total_qw),
        .fifo_full (tx_full),
        .wr_en     (tx_wr_en),
        .wr_data   (tx_wr_data),
        .count     (tx_count),
        .running   (busy)
    );

    ipg_rx_check #(.CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .cmd_go     (cmd_wr),
        .cmd        (cmd_fields),
        .fifo_empty (rx_empty),
        .rd_data    (rx_rd_data),
        .rd_en      (rx_rd_en),
        .count      (rx_count),
        .fail       (fail)
    );

    ipg_xfer_timer #(.CNT_W(CNT_W), .TIMER_W(TIMER_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clear    (cmd_wr),
        .first_wr (tx_wr_en),
        .rx_count (rx_count),
        .total    (total_qw),
        .value    (timer_val)
    );

    assign timer_lo = timer_val[31:0];
    assign timer_hi = timer_val[TIMER_W-1:32];

endmodule

// File: rtl/incr_pattern_tester_chk.sv
module incr_pattern_tester_chk #(
    parameter int CNT_W   = 32,
    parameter int TIMER_W = 48
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_wr,
    input logic                cmd_stop,
    input logic [CNT_W-1:0]    total_qw,
    input logic                tx_full,
    input logic                tx_wr_en,
    input logic [63:0]         tx_wr_data,
    input logic                rx_rd_en,
    input logic                busy,
    input logic                fail,
    input logic [CNT_W-1:0]    tx_count,
    input logic [CNT_W-1:0]    rx_count,
    input logic [31:0]         timer_lo,
    input logic [TIMER_W-33:0] timer_hi
);

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_stop) |=> busy); // R1

    AST_HOLD_KEEPS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_stop) |=> !busy); // R1

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        tx_full |-> !tx_wr_en); // R2

    AST_LANES_CONSECUTIVE: assert property (@(posedge clk) disable iff (rst)
        tx_wr_en |-> (tx_wr_data[63:32] == tx_wr_data[31:0] + 32'd1)); // R3

    AST_LAST_WRITE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (busy && tx_wr_en && !cmd_wr && (tx_count == total_qw - CNT_W'(1))) |=> !busy); // R4

    AST_RX_COUNT_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        !rx_rd_en ##1 !cmd_wr |=> $stable(rx_count)); // R5

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !cmd_wr) |=> fail); // R8

    AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (tx_count == '0 && rx_count == '0 && !fail)); // R9

    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rx_count == total_qw && !cmd_wr) ##1 !cmd_wr |=> $stable({timer_hi, timer_lo})); // R10

endmodule

bind incr_pattern_tester incr_pattern_tester_chk #(.CNT_W(CNT_W), .TIMER_W(TIMER_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .cmd_stop   (cmd_stop),
    .total_qw   (total_qw),
    .tx_full    (tx_full),
    .tx_wr_en   (tx_wr_en),
    .tx_wr_data (tx_wr_data),
    .rx_rd_en   (rx_rd_en),
    .busy       (busy),
    .fail       (fail),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .timer_lo   (timer_lo),
    .timer_hi   (timer_hi)
);

// File: tb/incr_pattern_tester_tb.sv
`timescale 1ns/1ps
module incr_pattern_tester_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        cmd_verify = 1'b0;
    logic [31:0] total_qw = '0;
    logic        tx_full = 1'b0;
    logic        tx_wr_en;
    logic [63:0] tx_wr_data;
    logic        rx_empty = 1'b1;
    logic        rx_rd_en;
    logic [63:0] rx_rd_data = '0;
    logic        busy;
    logic        fail;
    logic [31:0] tx_count;
    logic [31:0] rx_count;
    logic [31:0] timer_lo;
    logic [15:0] timer_hi;

    always #2 clk = ~clk;

    incr_pattern_tester u_dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_stop   (cmd_stop),
        .cmd_verify (cmd_verify),
        .total_qw   (total_qw),
        .tx_full    (tx_full),
        .tx_wr_en   (tx_wr_en),
        .tx_wr_data (tx_wr_data),
        .rx_empty   (rx_empty),
        .rx_rd_en   (rx_rd_en),
        .rx_rd_data (rx_rd_data),
        .busy       (busy),
        .fail       (fail),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .timer_lo   (timer_lo),
        .timer_hi   (timer_hi)
    );

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [63:0] exp_q[$];
    logic [63:0] loop_q[$];
    bit          full_mode = 0;
    bit          stall = 0;
    int          corrupt_idx = -1;
    int          pop_idx = 0;
    bit          first_seen = 0;
    bit          done_seen = 0;
    bit          chk_idle = 0;
    int          first_n = 0;
    int          done_m = 0;
    logic [31:0] cur_total = '0;
    bit          finished = 0;

    function automatic logic [63:0] pat(input int unsigned n);
        logic [31:0] a;
        a = 32'(n * 2);
        return {a + 32'd1, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic report();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // FIFO model plus scoreboard monitor
    initial begin
        forever begin
            logic        wr;
            logic        rd;
            logic [63:0] d;
            @(negedge clk);
            wr = tx_wr_en;
            rd = rx_rd_en;
            d  = tx_wr_data;
            if (chk_idle) begin
                check(!busy, "R4 busy after last write", 64'(busy), 64'd0);
                chk_idle = 0;
            end
            if (tx_full) check(!wr, "R2 write while full", 64'(wr), 64'd0);
            if (busy && !tx_full) check(wr, "R2 write with room", 64'(wr), 64'd1);
            check(rd == !rx_empty, "R5 read enable", 64'(rd), 64'(!rx_empty));
            if (wr) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4 extra write", d, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check(d == e, "R3 write data", d, e);
                    if (exp_q.size() == 0) chk_idle = 1;
                end
                if (!first_seen) begin
                    first_seen = 1;
                    first_n = cyc;
                end
            end
            if (!done_seen && first_seen && rx_count == cur_total) begin
                done_seen = 1;
                done_m = cyc;
            end
            @(posedge clk);
            cyc++;
            #1;
            if (rd) begin
                logic [63:0] v;
                v = loop_q.pop_front();
                if (pop_idx == corrupt_idx) v = v ^ 64'h20;
                rx_rd_data = v;
                pop_idx++;
            end
            if (wr) loop_q.push_back(d);
            rx_empty = stall || (loop_q.size() == 0);
            tx_full  = full_mode && (cyc % 3 == 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    task automatic run(input int unsigned total, input bit verify, input bit hold,
                       input bit fm, input int corrupt, input int stall_cyc, input bit exp_fail);
        full_mode   = fm;
        corrupt_idx = corrupt;
        pop_idx     = 0;
        first_seen  = 0;
        done_seen   = 0;
        cur_total   = total;
        stall       = (stall_cyc > 0);
        exp_q.delete();
        if (!hold) for (int i = 0; i < int'(total); i++) exp_q.push_back(pat(i));
        @(posedge clk); #1;
        total_qw = total; cmd_wr = 1; cmd_stop = hold; cmd_verify = verify;
        @(posedge clk); #1;
        cmd_wr = 0;
        @(negedge clk);
        check(tx_count == 0 && rx_count == 0, "R9 counts cleared", {tx_count, rx_count}, 64'd0);
        check(!fail, "R9 fail cleared", 64'(fail), 64'd0);
        check({timer_hi, timer_lo} == 48'd0, "R9 timer cleared", 64'({timer_hi, timer_lo}), 64'd0);
        if (hold) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                check(!busy && !tx_wr_en, "R1 hold command stays idle", {busy, tx_wr_en}, 64'd0);
            end
            check(tx_count == 0, "R1 no words sent", 64'(tx_count), 64'd0);
            check({timer_hi, timer_lo} == 48'd0, "R10 timer idle", 64'({timer_hi, timer_lo}), 64'd0);
            return;
        end
        check(busy, "R1 busy after start", 64'(busy), 64'd1);
        if (stall_cyc > 0) begin
            repeat (stall_cyc) @(negedge clk);
            check(rx_count == 0, "R5 no count while empty", 64'(rx_count), 64'd0);
            stall = 0;
        end
        for (int g = 0; g < 5000 && !done_seen; g++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(tx_count == total, "R4 tx_count", 64'(tx_count), 64'(total));
        check(!busy, "R4 busy low", 64'(busy), 64'd0);
        check(exp_q.size() == 0, "R4 all words written", 64'(exp_q.size()), 64'd0);
        check(rx_count == total, "R5 rx_count", 64'(rx_count), 64'(total));
        check(timer_hi == 16'd0 && timer_lo == 32'(done_m - first_n), "R10 timer value",
              64'({timer_hi, timer_lo}), 64'(done_m - first_n));
        begin
            logic [47:0] t0;
            t0 = {timer_hi, timer_lo};
            repeat (10) @(negedge clk);
            check({timer_hi, timer_lo} == t0, "R10 timer holds", 64'({timer_hi, timer_lo}), 64'(t0));
        end
        check(fail == exp_fail, verify ? "R6 fail flag" : "R7 fail ignored", 64'(fail), 64'(exp_fail));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(!busy && !fail && !tx_wr_en, "R9 reset outputs", {busy, fail, tx_wr_en}, 64'd0);
        check(tx_count == 0 && rx_count == 0, "R9 reset counts", {tx_count, rx_count}, 64'd0);
        @(posedge clk); #1;
        rst = 0;

        run(8,  1, 0, 0, -1, 0,  0);   // R3 R4 R5 basic
        run(20, 1, 0, 1, -1, 0,  0);   // R2 with full pattern
        run(1,  1, 0, 0, -1, 0,  0);   // R11 single word
        check(tx_count == 1 && rx_count == 1, "R11 single word run", {tx_count, rx_count}, {32'd1, 32'd1});
        run(12, 1, 0, 0, 5, 0,   1);   // R6 corrupted word
        repeat (20) @(negedge clk);
        check(fail, "R8 fail sticky", 64'(fail), 64'd1);
        run(12, 0, 1, 0, -1, 0,  0);   // R1 hold, R8 cleared by command
        run(10, 0, 0, 1, 3, 0,   0);   // R7 verify off
        run(6,  1, 0, 0, -1, 30, 0);   // R5 stalled receive
        report();
    end

endmodule